// File: doc/BRIEF.md
# Signed Five-Bit Arithmetic Unit with Two-Digit Display Decoder

This block is purely combinational. It takes two 5-bit two's-complement operands, so each lies between -16 and +15, and a 3-bit operation code. From these it produces a 5-bit result and three flags. The overflow flag marks a result that cannot be represented. The status flag carries the answer of a comparison. The negative flag follows the sign of the result.

The result also goes to a display decoder. The decoder drives two static, active-high seven-segment patterns: a tens/sign digit and a units digit. Segment bit 0 is segment a, and so on up to bit 6, which is segment g. The block needs no clock and no reset, and all outputs settle directly from the inputs.

Top module: `alu5_display_top`

## Requirements
- R1: Operation code 000 drives the result to the sum of the operands, wrapped to 5 bits. Overflow is high exactly when the true sum lies outside -16..+15.
- R2: Operation code 001 drives the result to operand A minus operand B, wrapped to 5 bits. Overflow is high exactly when the true difference lies outside -16..+15.
- R3: Operation code 010 gives the signed minimum of the two operands. Operation code 011 gives the signed maximum.
- R4: Operation code 100 sets status to (A > B, signed). Operation code 101 sets status to (A <= B, signed). For both codes the result is 00000.
- R5: Operation code 110 gives the absolute value of A. For A = -16 the result is 10000 and overflow is high. Overflow is low for every other A.
- R6: Operation code 111 gives A shifted left by two places with zero fill. Overflow is high exactly when the three most significant bits of A are not all equal.
- R7: Overflow is low for operation codes 010 through 101. Status is low for every code other than 100 and 101.
- R8: The negative flag equals bit 4 of the result.
- R9: The units pattern shows the magnitude of the signed result modulo 10, where the magnitude of 10000 is 16. The patterns are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F and 9=6F, in hex.
- R10: The tens pattern works as follows. When the magnitude is 10 or more, it shows the digit of magnitude/10 with the same patterns. Otherwise, for a negative result it shows a minus sign, segment g only (40 hex). For a non-negative result it is blank (00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 5 | Operand A, two's complement |
| op_b | input | 5 | Operand B, two's complement |
| op_sel | input | 3 | Operation code |
| result | output | 5 | Operation result |
| ovf_flag | output | 1 | Result not representable |
| cmp_flag | output | 1 | Comparison answer |
| neg_flag | output | 1 | Result is negative |
| seg_tens | output | 7 | Tens digit or minus sign pattern, active high |
| seg_units | output | 7 | Units digit pattern, active high |

## Verification
Directed vectors come first. They target the edges of the signed range for addition and subtraction (+15+1, -16-1, -16+15), so that wrapping can be told apart from true results. Equal and opposite-sign operands separate signed from unsigned ordering in the minimum, maximum and comparison codes. The two unrepresentable cases, -16 for absolute value and values whose top bits disagree for the shift, are each tried on both sides of the boundary. A full sweep of every operand pair under all eight codes then checks each output against an integer model. This sweep also covers every displayable value, including -16 and the negative two-digit values.

// File: rtl/alu5_pkg.sv
package alu5_pkg;

    localparam int unsigned OPND_W = 5;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned SEG_W  = 7;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_MIN  = 3'b010,
        OP_MAX  = 3'b011,
        OP_GT   = 3'b100,
        OP_LE   = 3'b101,
        OP_ABS  = 3'b110,
        OP_SHL2 = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic [OPND_W-1:0] value;
        logic              ovf;
        logic              status;
        logic              neg;
    } alu_out_t;

    localparam logic [SEG_W-1:0] GLYPH_MINUS = 7'h40;
    localparam logic [SEG_W-1:0] GLYPH_BLANK = 7'h00;

    // segment bit 0 = a ... bit 6 = g, active high
    function automatic logic [SEG_W-1:0] digit_glyph(input int unsigned d);
        logic [SEG_W-1:0] g;
        case (d)
            0:       g = 7'h3F;
            1:       g = 7'h06;
            2:       g = 7'h5B;
            3:       g = 7'h4F;
            4:       g = 7'h66;
            5:       g = 7'h6D;
            6:       g = 7'h7D;
            7:       g = 7'h07;
            8:       g = 7'h7F;
            9:       g = 7'h6F;
            default: g = GLYPH_MINUS;
        endcase
        return g;
    endfunction

    function automatic logic is_compare(input alu_op_e op);
        return (op == OP_GT) || (op == OP_LE);
    endfunction

endpackage

// File: rtl/alu5_core.sv
module alu5_core
    import alu5_pkg::*;
#(
    parameter int unsigned W = OPND_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output alu_out_t     res
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] sum_v;
    logic [W-1:0] diff_v;
    logic [W-1:0] neg_a;
    logic         a_gt_b;

    always_comb begin
        sum_v  = a + b;
        diff_v = a - b;
        neg_a  = W'(0) - a;
        a_gt_b = $signed(a) > $signed(b);

        res = '0;
        unique case (op)
            OP_ADD: begin
                res.value = sum_v;
                res.ovf   = (a[MSB] == b[MSB]) && (sum_v[MSB] != a[MSB]);
            end
            OP_SUB: begin
                res.value = diff_v;
                res.ovf   = (a[MSB] != b[MSB]) && (diff_v[MSB] != a[MSB]);
            end
            OP_MIN:  res.value = a_gt_b ? b : a;
            OP_MAX:  res.value = a_gt_b ? a : b;
            OP_GT:   res.status = a_gt_b;
            OP_LE:   res.status = !a_gt_b;
            OP_ABS: begin
                res.value = a[MSB] ? neg_a : a;
                res.ovf   = a[MSB] && neg_a[MSB];
            end
            OP_SHL2: begin
                res.value = {a[MSB-2:0], 2'b00};
                res.ovf   = !((a[MSB] == a[MSB-1]) && (a[MSB-1] == a[MSB-2]));
            end
            default: res = '0;
        endcase
        res.neg = res.value[MSB];
    end

    // R3: min/max always returns one of the operands
    always_comb begin
        if (op == OP_MIN || op == OP_MAX)
            a_r3_pick_operand: assert (res.value == a || res.value == b);
    end

    // R7: overflow never raised by min/max/compare
    always_comb begin
        if (op inside {OP_MIN, OP_MAX, OP_GT, OP_LE})
            a_r7_no_overflow: assert (!res.ovf);
    end

    // R5: absolute value is non-negative unless it overflowed
    always_comb begin
        if (op == OP_ABS && !res.ovf)
            a_r5_abs_nonneg: assert (!res.value[MSB]);
    end
endmodule

// File: rtl/alu5_sevenseg.sv
module alu5_sevenseg
    import alu5_pkg::*;
#(
    parameter int unsigned W  = OPND_W,
    parameter int unsigned SW = SEG_W
) (
    input  logic [W-1:0]  value,
    output logic [SW-1:0] seg_tens,
    output logic [SW-1:0] seg_units
);
    localparam int unsigned  MSB = W - 1;
    localparam logic [W-1:0] TEN = W'(10);

    logic [W-1:0] mag;
    logic [W-1:0] tens_v;
    logic [W-1:0] units_v;

    always_comb begin
        mag     = value[MSB] ? (W'(0) - value) : value;
        tens_v  = mag / TEN;
        units_v = mag % TEN;

        seg_units = digit_glyph(32'(units_v));
        if (mag >= TEN)
            seg_tens = digit_glyph(32'(tens_v));
        else if (value[MSB])
            seg_tens = GLYPH_MINUS;
        else
            seg_tens = GLYPH_BLANK;
    end

    // R9: the units digit always lights at least one segment
    always_comb begin
        a_r9_units_lit: assert (seg_units != '0);
    end

    // R10: a blank tens digit only for non-negative results
    always_comb begin
        if (seg_tens == GLYPH_BLANK)
            a_r10_blank_nonneg: assert (!value[MSB]);
    end
endmodule

// File: rtl/alu5_display_top.sv
module alu5_display_top
    import alu5_pkg::*;
(
    input  logic [4:0] op_a,
    input  logic [4:0] op_b,
    input  logic [2:0] op_sel,
    output logic [4:0] result,
    output logic       ovf_flag,
    output logic       cmp_flag,
    output logic       neg_flag,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_units
);
    alu_out_t core_out;
    alu_op_e  op;

    assign op = alu_op_e'(op_sel);

    alu5_core #(.W(OPND_W)) u_core (
        .a   (op_a),
        .b   (op_b),
        .op  (op),
        .res (core_out)
    );

    assign result   = core_out.value;
    assign ovf_flag = core_out.ovf;
    assign cmp_flag = core_out.status;
    assign neg_flag = core_out.neg;

    alu5_sevenseg #(.W(OPND_W), .SW(SEG_W)) u_seg (
        .value     (core_out.value),
        .seg_tens  (seg_tens),
        .seg_units (seg_units)
    );

    // R4: comparison codes leave the result at zero
    always_comb begin
        if (is_compare(op))
            a_r4_cmp_zero: assert (result == '0 && !neg_flag);
    end

    // R7: status only for comparison codes
    always_comb begin
        if (!is_compare(op))
            a_r7_status_low: assert (!cmp_flag);
    end
endmodule

// File: tb/alu5_display_top_tb.sv
module alu5_display_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [4:0] op_a = '0;
    logic [4:0] op_b = '0;
    logic [2:0] op_sel = '0;
    logic [4:0] result;
    logic       ovf_flag, cmp_flag, neg_flag;
    logic [6:0] seg_tens, seg_units;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu5_display_top u_dut (
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .result(result), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
        .neg_flag(neg_flag), .seg_tens(seg_tens), .seg_units(seg_units)
    );

    function automatic logic [6:0] ref_glyph(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic int sval(input logic [4:0] v);
        return v[4] ? int'(v) - 32 : int'(v);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d op=%0d)",
                     tag, act, exp, sval(op_a), sval(op_b), op_sel);
        end
    endtask

    // drive one vector, compute expectations from integer arithmetic, compare
    task automatic run_vec(input int a, input int b, input int op);
        int sa, sb, t, mag, fv;
        logic [4:0] ef;
        bit eo, es;
        string rtag;
        @(posedge clk);
        op_a = 5'(a); op_b = 5'(b); op_sel = 3'(op);
        sa = sval(5'(a)); sb = sval(5'(b));
        eo = 0; es = 0; t = 0;
        case (op)
            0: begin t = sa + sb; eo = (t > 15 || t < -16); rtag = "R1"; end
            1: begin t = sa - sb; eo = (t > 15 || t < -16); rtag = "R2"; end
            2: begin t = (sa < sb) ? sa : sb; rtag = "R3"; end
            3: begin t = (sa > sb) ? sa : sb; rtag = "R3"; end
            4: begin t = 0; es = (sa > sb); rtag = "R4"; end
            5: begin t = 0; es = (sa <= sb); rtag = "R4"; end
            6: begin t = (sa < 0) ? -sa : sa; eo = (t > 15); rtag = "R5"; end
            default: begin t = sa * 4; eo = (t > 15 || t < -16); rtag = "R6"; end
        endcase
        ef = 5'(t);
        fv = sval(ef);
        mag = (fv < 0) ? -fv : fv;
        @(negedge clk);
        chk(rtag, int'(result), int'(ef));
        chk((op >= 2 && op <= 5) ? "R7 ovf" : {rtag, " ovf"}, int'(ovf_flag), int'(eo));
        chk((op == 4 || op == 5) ? "R4 status" : "R7 status", int'(cmp_flag), int'(es));
        chk("R8", int'(neg_flag), int'(ef[4]));
        chk("R9", int'(seg_units), int'(ref_glyph(mag % 10)));
        chk("R10", int'(seg_tens),
            int'((mag >= 10) ? ref_glyph(mag / 10) : (fv < 0 ? 7'h40 : 7'h00)));
    endtask

    task automatic t_idle_state();
        run_vec(0, 0, 0); // all-zero inputs: zero result, units shows 0
    endtask

    task automatic t_add();        // R1
        run_vec(15, 1, 0); run_vec(-16, -1, 0); run_vec(-16, 15, 0); run_vec(7, 8, 0);
    endtask

    task automatic t_sub();        // R2
        run_vec(-16, 1, 1); run_vec(15, -1, 1); run_vec(0, -16, 1); run_vec(-1, -16, 1);
    endtask

    task automatic t_minmax();     // R3
        run_vec(-3, 2, 2); run_vec(-3, 2, 3); run_vec(5, 5, 2); run_vec(-16, 15, 3);
    endtask

    task automatic t_compare();    // R4, R7
        run_vec(1, -1, 4); run_vec(-1, 1, 4); run_vec(4, 4, 4);
        run_vec(4, 4, 5); run_vec(-16, 15, 5); run_vec(15, -16, 5);
    endtask

    task automatic t_abs();        // R5
        run_vec(-16, 0, 6); run_vec(-15, 0, 6); run_vec(15, 0, 6); run_vec(0, 0, 6);
    endtask

    task automatic t_shift();      // R6
        run_vec(3, 0, 7); run_vec(4, 0, 7); run_vec(-4, 0, 7); run_vec(-5, 0, 7);
    endtask

    task automatic t_display();    // R8, R9, R10
        run_vec(-12, 0, 2); run_vec(-9, 0, 2); run_vec(10, 0, 2); run_vec(9, 0, 2);
    endtask

    task automatic t_sweep();
        for (int op = 0; op < 8; op++)
            for (int a = -16; a < 16; a++)
                for (int b = -16; b < 16; b++)
                    run_vec(a, b, op);
    endtask

    initial begin
        t_idle_state();
        t_add();
        t_sub();
        t_minmax();
        t_compare();
        t_abs();
        t_shift();
        t_display();
        t_sweep();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule